// File: doc/BRIEF.md
# RS-485 Transceiver Direction Control

This block sits beside one UART channel and drives the direction pins of an external RS-422 or RS-485 line transceiver, so the board needs no extra gates for that. A single 8-bit control byte, written and read through a plain bus port, sets the asserted level of a transmit-enable and a receive-enable. It also picks whether each enable is static or follows the serializer's busy status. A 2-bit routing field then chooses which of four physical pins carry those enables.

When routing is off, the four pins pass through the channel's own active-low modem and ready signals: request-to-send, terminal-ready, transmit-ready and receive-ready. The transmit enable can instead be placed on the request-to-send pin or on the terminal-ready pin. A third routing setting places the transmit enable on the transmit-ready pin and the receive enable on the receive-ready pin. Every pin is driven from a flop, so the enables change only on clock edges.

Top module: `rs485_dir_ctl`

## Requirements
- R1: After reset the control byte reads 0x80 and all four pins are high.
- R2: A write stores bits 7:4 and 1:0 of the written byte. Bits 3:2 always read back as 0. The read port shows the stored byte at all times.
- R3: With bit 4 clear, the transmit enable equals bit 5 whatever the busy input does.
- R4: With bit 4 set, the transmit enable equals bit 5 while busy is 1 and the complement of bit 5 while busy is 0.
- R5: The receive enable equals bit 7. The exception is routing 11 with bit 6 set: the receive enable then equals bit 7 while busy is 0 and its complement while busy is 1.
- R6: Routing field bits 1:0 = 00 drives each pin with its own input signal.
- R7: Routing 01 drives the request-to-send pin with the transmit enable. The other three pins pass their own inputs.
- R8: Routing 10 drives the terminal-ready pin with the transmit enable. The other three pins pass their own inputs.
- R9: Routing 11 drives the transmit-ready pin with the transmit enable and the receive-ready pin with the receive enable. The request-to-send and terminal-ready pins pass their own inputs.
- R10: Each pin takes the value computed from the inputs and the stored byte at one clock edge. A byte written at one edge affects the pins at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Stored control byte |
| tx_busy | input | 1 | Serializer is transmitting |
| rts_n_in | input | 1 | Request-to-send from the channel |
| dtr_n_in | input | 1 | Terminal-ready from the channel |
| txrdy_n_in | input | 1 | Transmit-ready from the channel |
| rxrdy_n_in | input | 1 | Receive-ready from the channel |
| rts_pin | output | 1 | Request-to-send pin or transmit enable |
| dtr_pin | output | 1 | Terminal-ready pin or transmit enable |
| txrdy_pin | output | 1 | Transmit-ready pin or transmit enable |
| rxrdy_pin | output | 1 | Receive-ready pin or receive enable |

## Verification
A control write and a busy transition can land on the same clock edge. At that edge the pins must use the new busy value with the old control byte, and only at the next edge the new byte. The bench provokes this with a directed case that flips routing, polarity and busy together, and it also lets random writes collide with random busy changes. Its reference model evaluates each edge with the byte held before that edge and compares all four pins and the read port in every cycle.

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tx_busy,
  input  logic       rts_n_in,
  input  logic       dtr_n_in,
  input  logic       txrdy_n_in,
  input  logic       rxrdy_n_in,
  output logic       rts_pin,
  output logic       dtr_pin,
  output logic       txrdy_pin,
  output logic       rxrdy_pin
);

  logic [5:0] ctrl_q;
  logic [1:0] route;
  logic       rx_pol, rx_auto, tx_pol, tx_auto;
  logic       txen, rxen;
  logic [3:0] pins_d, pins_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctrl_q <= 6'b100000;
    else if (wr_en) ctrl_q <= {wr_data[7:4], wr_data[1:0]};

  assign rd_data = {ctrl_q[5:2], 2'b00, ctrl_q[1:0]};
  assign {rx_pol, rx_auto, tx_pol, tx_auto, route} = ctrl_q;

  assign txen = tx_auto ? (tx_busy ? tx_pol : ~tx_pol) : tx_pol;
  assign rxen = (route == 2'b11 && rx_auto) ? (tx_busy ? ~rx_pol : rx_pol) : rx_pol;

  always_comb begin
    pins_d = {rts_n_in, dtr_n_in, txrdy_n_in, rxrdy_n_in};
    case (route)
      2'b01:   pins_d[3] = txen;
      2'b10:   pins_d[2] = txen;
      2'b11:   pins_d[1:0] = {txen, rxen};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pins_q <= 4'hF;
    else        pins_q <= pins_d;

  assign {rts_pin, dtr_pin, txrdy_pin, rxrdy_pin} = pins_q;

endmodule

module rs485_dir_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       tx_busy,
  input logic       rts_n_in,
  input logic       dtr_n_in,
  input logic       txrdy_n_in,
  input logic       rxrdy_n_in,
  input logic       rts_pin,
  input logic       dtr_pin,
  input logic       txrdy_pin,
  input logic       rxrdy_pin
);

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & 8'hF3));

  // R2
  hold_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == 2'b00 |=>
      {rts_pin, dtr_pin, txrdy_pin, rxrdy_pin} ==
      $past({rts_n_in, dtr_n_in, txrdy_n_in, rxrdy_n_in}));

  // R3
  tx_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b01 && !rd_data[4]) |=> rts_pin == $past(rd_data[5]));

  // R8
  dtr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b10 && rd_data[4]) |=>
      dtr_pin == ($past(tx_busy) ? $past(rd_data[5]) : !$past(rd_data[5])));

  // R5
  rx_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b11 && rd_data[6]) |=>
      rxrdy_pin == ($past(tx_busy) ? !$past(rd_data[7]) : $past(rd_data[7])));

endmodule

bind rs485_dir_ctl rs485_dir_ctl_chk u_chk (.*);

// File: tb/rs485_dir_ctl_bench.sv
module rs485_dir_ctl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic tx_busy = 1'b0;
  logic rts_n_in = 1'b1, dtr_n_in = 1'b1, txrdy_n_in = 1'b1, rxrdy_n_in = 1'b1;
  logic rts_pin, dtr_pin, txrdy_pin, rxrdy_pin;

  int checks = 0;
  int failures = 0;
  string focus = "R1";

  logic [7:0] m_ctrl = 8'h80;
  logic [3:0] m_pins = 4'hF;
  logic [1:0] m_route = 2'b00;

  always #10 clk = ~clk;

  rs485_dir_ctl u_rs485_dir_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tx_busy(tx_busy), .rts_n_in(rts_n_in), .dtr_n_in(dtr_n_in),
    .txrdy_n_in(txrdy_n_in), .rxrdy_n_in(rxrdy_n_in),
    .rts_pin(rts_pin), .dtr_pin(dtr_pin), .txrdy_pin(txrdy_pin), .rxrdy_pin(rxrdy_pin));

  function automatic logic [3:0] exp_pins(input logic [7:0] c, input logic busy,
                                          input logic [3:0] ins);
    logic te, re;
    logic [3:0] p;
    te = c[4] ? (busy ? c[5] : ~c[5]) : c[5];
    re = (c[1:0] == 2'b11 && c[6]) ? (busy ? ~c[7] : c[7]) : c[7];
    p = ins;
    if (c[1:0] == 2'b01) p[3] = te;
    if (c[1:0] == 2'b10) p[2] = te;
    if (c[1:0] == 2'b11) p[1:0] = {te, re};
    return p;
  endfunction

  function automatic string route_req(input logic [1:0] r);
    case (r)
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h80;
      m_pins = 4'hF;
      m_route = 2'b00;
    end else begin
      m_pins = exp_pins(m_ctrl, tx_busy, {rts_n_in, dtr_n_in, txrdy_n_in, rxrdy_n_in});
      m_route = m_ctrl[1:0];
      if (wr_en) m_ctrl = wr_data & 8'hF3;
    end
  end

  task automatic check_all();
    logic [3:0] got;
    got = {rts_pin, dtr_pin, txrdy_pin, rxrdy_pin};
    checks++;
    if (got !== m_pins) begin
      failures++;
      $display("FAIL %s/%s pins actual=%b expected=%b", focus, route_req(m_route), got, m_pins);
    end
    checks++;
    if (rd_data !== m_ctrl) begin
      failures++;
      $display("FAIL %s/R2 rd_data actual=%h expected=%h", focus, rd_data, m_ctrl);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic busy,
                      input logic [3:0] ins);
    wr_en = we;
    wr_data = wd;
    tx_busy = busy;
    {rts_n_in, dtr_n_in, txrdy_n_in, rxrdy_n_in} = ins;
    @(negedge clk);
    check_all();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_0485));
    repeat (3) @(negedge clk);
    focus = "R1";
    check_all();
    rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b0, 4'b0101);

    focus = "R2";
    step(1'b1, 8'hFF, 1'b0, 4'b1111);
    step(1'b1, 8'h0C, 1'b1, 4'b0000);

    focus = "R3";
    step(1'b1, 8'h21, 1'b0, 4'b0000);
    for (int i = 0; i < 6; i++) step(1'b0, 8'h00, logic'(i[0]), 4'b0011);

    focus = "R4";
    step(1'b1, 8'h32, 1'b0, 4'b1111);
    for (int i = 0; i < 6; i++) step(1'b0, 8'h00, logic'(i[1]), 4'b1010);
    step(1'b1, 8'h13, 1'b1, 4'b0000);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, logic'(i[0]), 4'b1100);

    focus = "R5";
    step(1'b1, 8'hC3, 1'b0, 4'b0000);
    for (int i = 0; i < 6; i++) step(1'b0, 8'h00, logic'(i[0]), 4'b1111);
    step(1'b1, 8'h43, 1'b1, 4'b0000);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, logic'(i[0]), 4'b0110);
    step(1'b1, 8'hC1, 1'b1, 4'b0000);
    step(1'b0, 8'h00, 1'b0, 4'b0000);

    focus = "R10";
    step(1'b1, 8'h73, 1'b0, 4'b0000);
    step(1'b1, 8'h90, 1'b1, 4'b1001);
    step(1'b1, 8'h33, 1'b0, 4'b0110);
    step(1'b1, 8'h12, 1'b1, 4'b1111);
    step(1'b0, 8'h00, 1'b0, 4'b0000);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0] == 3'd0, r[15:8], r[16], r[20:17]);
    end
    report();
  end

endmodule